// File: doc/BRIEF.md
# Address Translation Permission Completion Builder

This block sits after the page walk in an I/O memory management unit. It turns one finished walk into one Success completion for a device that asked for an address translation. It takes two kinds of input. The first is the two request attributes: a no-write flag, and a flag that asks for execute. The second is the walk outcome: an entry-present bit, a fault bit with a cause code, the page's read, write and execute permissions, and the physical page number. From these it produces the granted R, W and X bits and the translated page number. It also reports whether a fault record would be written to the fault log or suppressed.

The block handles two cases differently. A translation that did not complete is returned as a Success completion with every permission cleared, and nothing is logged for it. This covers an absent entry and the page-fault causes. A translation that did complete, but lacks some requested permission, keeps the page's own bits and clears only the denied ones. W and X are granted only together with R.

Both sides use valid/ready. A walk result is taken on a cycle where `res_valid` and `res_ready` are both high. Its completion is registered and is presented on the next cycle. While a completion waits on `cpl_ready`, the block holds `res_ready` low and keeps the completion unchanged. When the completion is taken in a cycle, a new result may be accepted in that same cycle, so the stage can run back to back.

Top module: `ats_perm_resp`

## Requirements
- R1: A result with `res_present`=0, or with `res_fault`=1 and `res_cause` equal to 12, 13 or 15 (instruction, read, write/AMO page fault), yields R=0, W=0, X=0 whatever the page permissions; `res_fault`=1 takes priority over `res_present`.
- R2: For the R1 cases, `cpl_suppr`=1 and `cpl_log_en`=0; for `res_fault`=1 with any other cause, `cpl_log_en`=1, `cpl_suppr`=0 and R=W=X=0; for a completed translation both are 0.
- R3: `cpl_addr` equals `res_ppn` when R=1 and is all zeros when R=0.
- R4: For a completed translation (`res_present`=1, `res_fault`=0), R equals the page read permission `res_pr`.
- R5: W is 1 only when R=1, `res_pw`=1 and `res_nowrite`=0; a write request on a read-only page completes with R=1, W=0.
- R6: X is 1 only when R=1, `res_px`=1 and `res_exec_req`=1; an execute-capable page gives X=0 when execute was not requested.
- R7: The completion for a result accepted at a clock edge is valid from that edge on, one cycle later, and completions keep acceptance order.
- R8: While `cpl_valid`=1 and `cpl_ready`=0, `res_ready` is 0 and every completion output holds its value.
- R9: During and right after reset, `cpl_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Walk result valid |
| res_ready | output | 1 | Walk result can be taken |
| res_nowrite | input | 1 | Request asked for no write permission |
| res_exec_req | input | 1 | Request asked for execute permission |
| res_present | input | 1 | Page entry present |
| res_fault | input | 1 | Walk ended in a fault |
| res_cause | input | CAUSE_W | Fault cause code |
| res_pr | input | 1 | Page read permission |
| res_pw | input | 1 | Page write permission |
| res_px | input | 1 | Page execute permission |
| res_ppn | input | PPN_W | Physical page number |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken |
| cpl_r | output | 1 | Granted read |
| cpl_w | output | 1 | Granted write |
| cpl_x | output | 1 | Granted execute |
| cpl_addr | output | PPN_W | Translated page number, zero when R=0 |
| cpl_log_en | output | 1 | A fault record would be written |
| cpl_suppr | output | 1 | A fault record is suppressed |

## Verification
The assertions assume the source keeps a result steady from the cycle it raises `res_valid` until that result is taken. They also assume that `res_cause` only has meaning while `res_fault` is high. The bench honours both assumptions. It draws a fresh item only after the previous one was accepted, and it chooses causes separately for page faults (12, 13, 15) and for other faults. Random stalls on `cpl_ready` exercise the hold-off and stability rules. Directed items come first, and they cover the read-only-page write, the unrequested execute and the no-read page.

// File: rtl/ats_perm_pkg.sv
package ats_perm_pkg;

  // cause codes that mark an uncompleted translation (no log entry)
  localparam int unsigned CAUSE_INSTR_PF = 12;
  localparam int unsigned CAUSE_LOAD_PF  = 13;
  localparam int unsigned CAUSE_STORE_PF = 15;

  typedef enum logic [1:0] {
    WALK_GRANT      = 2'd0,
    WALK_ABSENT     = 2'd1,
    WALK_PAGE_FAULT = 2'd2,
    WALK_OTHER      = 2'd3
  } walk_class_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  typedef struct packed {
    perm_t perm;
    logic  log_en;
    logic  suppr;
  } cpl_flags_t;

  localparam int unsigned FLAGS_W = $bits(cpl_flags_t);

endpackage

// File: rtl/ats_walk_classify.sv
module ats_walk_classify
  import ats_perm_pkg::*;
#(
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               present,
  input  logic               fault,
  input  logic [CAUSE_W-1:0] cause,
  output walk_class_e        cls
);

  logic is_pf;

  always_comb begin
    is_pf = (cause == CAUSE_W'(CAUSE_INSTR_PF)) ||
            (cause == CAUSE_W'(CAUSE_LOAD_PF))  ||
            (cause == CAUSE_W'(CAUSE_STORE_PF));
  end

  // a fault wins over the present bit
  always_comb begin
    if (fault)
      cls = is_pf ? WALK_PAGE_FAULT : WALK_OTHER;
    else if (!present)
      cls = WALK_ABSENT;
    else
      cls = WALK_GRANT;
  end

endmodule

// File: rtl/ats_perm_mask.sv
module ats_perm_mask
  import ats_perm_pkg::*;
(
  input  walk_class_e cls,
  input  logic        nowrite,
  input  logic        exec_req,
  input  logic        pg_r,
  input  logic        pg_w,
  input  logic        pg_x,
  output cpl_flags_t  flags
);

  always_comb begin
    flags = '0;
    unique case (cls)
      WALK_GRANT: begin
        // write and execute only ride on read
        flags.perm.r = pg_r;
        flags.perm.w = pg_r & pg_w & ~nowrite;
        flags.perm.x = pg_r & pg_x & exec_req;
      end
      WALK_ABSENT, WALK_PAGE_FAULT: begin
        flags.suppr = 1'b1;
      end
      WALK_OTHER: begin
        flags.log_en = 1'b1;
      end
      default: flags = '0;
    endcase
  end

endmodule

// File: rtl/ats_cpl_stage.sv
module ats_cpl_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= in_data;
    end
  end

endmodule

// File: rtl/ats_perm_resp.sv
module ats_perm_resp
  import ats_perm_pkg::*;
#(
  parameter int unsigned CAUSE_W = 6,
  parameter int unsigned PPN_W   = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  output logic               res_ready,
  input  logic               res_nowrite,
  input  logic               res_exec_req,
  input  logic               res_present,
  input  logic               res_fault,
  input  logic [CAUSE_W-1:0] res_cause,
  input  logic               res_pr,
  input  logic               res_pw,
  input  logic               res_px,
  input  logic [PPN_W-1:0]   res_ppn,
  output logic               cpl_valid,
  input  logic               cpl_ready,
  output logic               cpl_r,
  output logic               cpl_w,
  output logic               cpl_x,
  output logic [PPN_W-1:0]   cpl_addr,
  output logic               cpl_log_en,
  output logic               cpl_suppr
);

  localparam int unsigned DW = FLAGS_W + PPN_W;

  walk_class_e      cls;
  cpl_flags_t       flags_d;
  cpl_flags_t       flags_q;
  logic [PPN_W-1:0] addr_d;
  logic [DW-1:0]    stage_in;
  logic [DW-1:0]    stage_out;

  ats_walk_classify #(.CAUSE_W(CAUSE_W)) u_cls (
    .present (res_present),
    .fault   (res_fault),
    .cause   (res_cause),
    .cls     (cls)
  );

  ats_perm_mask u_mask (
    .cls      (cls),
    .nowrite  (res_nowrite),
    .exec_req (res_exec_req),
    .pg_r     (res_pr),
    .pg_w     (res_pw),
    .pg_x     (res_px),
    .flags    (flags_d)
  );

  // address is only defined with read granted; zero it otherwise
  assign addr_d   = flags_d.perm.r ? res_ppn : '0;
  assign stage_in = {flags_d, addr_d};

  ats_cpl_stage #(.DW(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (res_valid),
    .in_ready  (res_ready),
    .in_data   (stage_in),
    .out_valid (cpl_valid),
    .out_ready (cpl_ready),
    .out_data  (stage_out)
  );

  assign flags_q    = cpl_flags_t'(stage_out[DW-1:PPN_W]);
  assign cpl_addr   = stage_out[PPN_W-1:0];
  assign cpl_r      = flags_q.perm.r;
  assign cpl_w      = flags_q.perm.w;
  assign cpl_x      = flags_q.perm.x;
  assign cpl_log_en = flags_q.log_en;
  assign cpl_suppr  = flags_q.suppr;

endmodule

// File: rtl/ats_perm_resp_chk.sv
module ats_perm_resp_chk #(
  parameter int unsigned PPN_W = 44
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic             cpl_valid,
  input logic             cpl_ready,
  input logic             cpl_r,
  input logic             cpl_w,
  input logic             cpl_x,
  input logic [PPN_W-1:0] cpl_addr,
  input logic             cpl_log_en,
  input logic             cpl_suppr
);

  assert_x_needs_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (!cpl_x || cpl_r));

  assert_w_needs_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (!cpl_w || cpl_r));

  assert_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_r) |-> (cpl_addr == '0));

  assert_no_log_suppr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_suppr) |-> (!cpl_log_en && !cpl_r));

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |-> !res_ready);

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_addr) && $stable(cpl_r)
      && $stable(cpl_w) && $stable(cpl_x) && $stable(cpl_log_en) && $stable(cpl_suppr)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> cpl_valid);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R9: assert (!cpl_valid);
    end
  end

endmodule

bind ats_perm_resp ats_perm_resp_chk #(.PPN_W(PPN_W)) u_chk (.*);

// File: tb/sim_ats_perm_resp.sv
`timescale 1ns/1ps
module sim_ats_perm_resp;

  localparam int unsigned CAUSE_W = 6;
  localparam int unsigned PPN_W   = 44;
  localparam int unsigned NCYC    = 4000;

  typedef struct {
    logic nowrite, exec_req, present, fault;
    logic [CAUSE_W-1:0] cause;
    logic pr, pw, px;
    logic [PPN_W-1:0] ppn;
  } item_t;

  typedef struct {
    logic r, w, x, log_en, suppr;
    logic [PPN_W-1:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, res_ready;
  logic res_nowrite = 1'b0, res_exec_req = 1'b0, res_present = 1'b0, res_fault = 1'b0;
  logic [CAUSE_W-1:0] res_cause = '0;
  logic res_pr = 1'b0, res_pw = 1'b0, res_px = 1'b0;
  logic [PPN_W-1:0] res_ppn = '0;
  logic cpl_valid, cpl_ready = 1'b0;
  logic cpl_r, cpl_w, cpl_x, cpl_log_en, cpl_suppr;
  logic [PPN_W-1:0] cpl_addr;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ats_perm_resp #(.CAUSE_W(CAUSE_W), .PPN_W(PPN_W)) u0 (.*);

  function automatic exp_t model(item_t it);
    exp_t e;
    logic pf, uncompl;
    pf      = it.fault && (it.cause == 12 || it.cause == 13 || it.cause == 15);
    uncompl = !it.present || it.fault;
    e.r      = !uncompl && it.pr;
    e.w      = e.r && it.pw && !it.nowrite;
    e.x      = e.r && it.px && it.exec_req;
    e.addr   = e.r ? it.ppn : '0;
    e.log_en = it.fault && !pf;
    e.suppr  = uncompl && !e.log_en;
    return e;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic item_t mk(logic nw, logic ex, logic pres, logic flt,
                               int cause, logic pr, logic pw, logic px);
    item_t it;
    it.nowrite = nw; it.exec_req = ex; it.present = pres; it.fault = flt;
    it.cause = CAUSE_W'(cause); it.pr = pr; it.pw = pw; it.px = px;
    it.ppn = {$urandom, $urandom};
    return it;
  endfunction

  function automatic item_t rnd_item();
    item_t it;
    int k;
    int other[4] = '{1, 5, 7, 14};
    it = mk(1'($urandom), 1'($urandom), 1'b1, 1'b0, $urandom % 64,
            1'($urandom), 1'($urandom), 1'($urandom));
    k = $urandom % 8;
    if (k == 0) it.present = 1'b0;
    else if (k == 1) begin
      it.fault = 1'b1;
      case ($urandom % 3)
        0: it.cause = 6'd12;
        1: it.cause = 6'd13;
        default: it.cause = 6'd15;
      endcase
    end else if (k == 2) begin
      it.fault = 1'b1;
      it.cause = CAUSE_W'(other[$urandom % 4]);
    end
    return it;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic drive(item_t it);
    res_nowrite = it.nowrite; res_exec_req = it.exec_req;
    res_present = it.present; res_fault = it.fault; res_cause = it.cause;
    res_pr = it.pr; res_pw = it.pw; res_px = it.px; res_ppn = it.ppn;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    item_t dq[$];
    exp_t  eq[$];
    item_t cur;
    exp_t  e, held;
    bit    took = 1'b1, stalled = 1'b0, fresh = 1'b0;

    void'($urandom(32'd1234));
    // R4 R5: write on read-only page -> R=1 W=0
    dq.push_back(mk(0, 0, 1, 0, 0, 1, 0, 0));
    // R6: execute page, execute not asked -> X=0
    dq.push_back(mk(0, 0, 1, 0, 0, 1, 1, 1));
    // R1 R2: page faults 12/13/15 with full perms
    dq.push_back(mk(0, 1, 1, 1, 12, 1, 1, 1));
    dq.push_back(mk(0, 1, 1, 1, 13, 1, 1, 1));
    dq.push_back(mk(0, 1, 1, 1, 15, 1, 1, 1));
    // R1: entry absent
    dq.push_back(mk(0, 1, 0, 0, 0, 1, 1, 1));
    // R2: other fault cause logs
    dq.push_back(mk(0, 1, 1, 1, 5, 1, 1, 1));
    // R4 R6: no read -> nothing
    dq.push_back(mk(0, 1, 1, 0, 0, 0, 1, 1));
    // R5 R6: no-write flag, execute asked
    dq.push_back(mk(1, 1, 1, 0, 0, 1, 1, 1));
    dq.push_back(mk(0, 1, 1, 0, 0, 1, 1, 1));

    repeat (3) @(negedge clk);
    check("R9 reset idle", 64'(cpl_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", 64'(cpl_valid), 64'd0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (stalled) begin
        check("R8 stall valid", 64'(cpl_valid), 64'd1);
        check("R8 stall hold", {cpl_r, cpl_w, cpl_x, cpl_log_en, cpl_suppr, cpl_addr},
              {held.r, held.w, held.x, held.log_en, held.suppr, held.addr});
      end
      if (fresh) check("R7 one-cycle latency", 64'(cpl_valid), 64'd1);
      if (took) begin
        cur = (dq.size() != 0) ? dq.pop_front() : rnd_item();
        drive(cur);
        res_valid = (cyc < 12) ? 1'b1 : ($urandom % 4 != 0);
      end else if (!res_valid) begin
        res_valid = ($urandom % 4 != 0);
      end
      cpl_ready = (cyc < 30) ? 1'b1 : ($urandom % 3 != 0);
      #1;
      stalled = 1'b0;
      if (cpl_valid) begin
        if (eq.size() == 0) check("R7 completion without request", 64'd1, 64'd0);
        else if (cpl_ready) begin
          e = eq.pop_front();
          check("R1 R4 read bit", 64'(cpl_r), 64'(e.r));
          check("R5 write bit", 64'(cpl_w), 64'(e.w));
          check("R6 execute bit", 64'(cpl_x), 64'(e.x));
          check("R3 address", 64'(cpl_addr), 64'(e.addr));
          check("R2 log/suppress", {cpl_log_en, cpl_suppr}, {e.log_en, e.suppr});
        end else begin
          check("R8 hold-off", 64'(res_ready), 64'd0);
          stalled = 1'b1;
          held.r = cpl_r; held.w = cpl_w; held.x = cpl_x;
          held.log_en = cpl_log_en; held.suppr = cpl_suppr; held.addr = cpl_addr;
        end
      end
      took  = res_valid && res_ready;
      fresh = took;
      if (took) eq.push_back(model(cur));
      if (took) res_valid = 1'b0 | res_valid;
    end
    @(negedge clk);
    finish_run();
  end

endmodule